// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing side of a serial port. A processor reaches it through a simple word-indexed register port. Each access is a full 32-bit word. The block holds a 16-byte receive queue that is fed by a byte-valid input. It sends one byte on a byte-valid output each time software writes the transmit data register. It also keeps a set of interrupt registers (raw, mask, acknowledge and masked) that drive a single level-sensitive interrupt line.

The receive data can be read in two ways, and both return the same status/data layout. The popping form removes the oldest byte. The peeking form leaves the queue untouched. Bit timing, baud generation and DMA are left to other blocks. The transmitter side always reports itself ready and idle.

One detail of the acknowledge path matters. After a transmit, the first acknowledge write cannot clear raw bit 0; only a later acknowledge can. The receive-pending interrupt bit is refreshed only when a register write happens or a byte is accepted.

Top module: `serport_regs`

## Requirements
- R1: After reset, the receive control register (index 2, byte offset 0x08) reads 0x00010000. Every other storage word reads 0, `irq` is low and `tx_valid` is low.
- R2: The receive queue keeps up to 16 bytes and returns them oldest first. A byte that arrives while 16 are held is dropped.
- R3: A status/data read (index 8 at 0x20, or index 9 at 0x24) returns the oldest byte in bits 7:0, bit 16 set when the queue holds data, and bits 22 and 24 always set. Read data appears on `rd_data` in the cycle after `rd_en`.
- R4: A read at index 8 removes the oldest byte when the queue is not empty. A read at index 9 never changes the queue. A pop and an arriving byte in the same cycle leave the count unchanged.
- R5: Raw interrupt bit 3 is set to "queue not empty" after each register write and after each accepted byte. A pop by itself does not change it.
- R6: A write to the data-out word (index 7, 0x1C) pulses `tx_valid` for one cycle with `tx_byte` equal to bits 7:0 of the write, starting the cycle after the write. The write also sets raw interrupt bits 0 and 1 and stores the whole word, which reads back at index 7.
- R7: A write to the acknowledge word (index 12, 0x30) clears each raw interrupt bit written as 1. If a transmit happened since the last acknowledge, bit 0 is first removed from the value. The value actually applied reads back at index 12.
- R8: The masked word (index 14, 0x38) reads raw AND mask, where the mask is at index 11 (0x2C). `irq` is high exactly when that value is non-zero.
- R9: Incoming bytes are accepted only while bit 3 of the receive control register is 1.
- R10: Indices 0, 1, 2, 3, 4, 5, 6, 7, 10 and 11 are plain read/write storage. Writes to index 14 have no effect. Index 15 always reads 0.
- R11: A write to the raw interrupt word (index 13, 0x34) stores the written value, except that bit 3 is forced to the queue's non-empty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 4 | Word index (byte offset / 4) |
| wr_en | input | 1 | Write strobe for `reg_idx` |
| rd_en | input | 1 | Read strobe for `reg_idx` |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
Every register result becomes visible one edge after its strobe. This covers read data, the transmit pulse, queue contents and the raw, acknowledge and mask effects. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, so each check lands one cycle after its stimulus. `irq` follows the registered raw and mask state with no added delay, so it is checked at the same falling edge as the write that changed those registers. The `tx_valid` pulse is checked at that falling edge and again one cycle later to confirm that it lasts a single cycle.

// File: rtl/serport_pkg.sv
// Shared constants for the serial port register front end.
// Assumes a 4-bit word index; offsets are byte offset / 4.
package serport_pkg;
    localparam int DW           = 32;
    localparam int IDX_W        = 4;
    localparam logic [IDX_W-1:0] IDX_DOUT   = 4'd7;
    localparam logic [IDX_W-1:0] IDX_POP    = 4'd8;
    localparam logic [IDX_W-1:0] IDX_PEEK   = 4'd9;
    localparam logic [IDX_W-1:0] IDX_MASK   = 4'd11;
    localparam logic [IDX_W-1:0] IDX_ACK    = 4'd12;
    localparam logic [IDX_W-1:0] IDX_RAW    = 4'd13;
    localparam logic [IDX_W-1:0] IDX_MASKED = 4'd14;
    localparam int IDX_RXCTRL   = 2;
    localparam int RXEN_BIT     = 3;
    localparam logic [DW-1:0] RXCTRL_RST = 32'h0001_0000;
    localparam int ST_AVAIL_BIT = 16;
    localparam int ST_IDLE_BIT  = 22;
    localparam int ST_READY_BIT = 24;
    localparam int RAW_RX_BIT   = 3;

    // True for indices backed by plain read/write storage.
    function automatic bit is_plain(int idx);
        return (idx <= 7) || (idx == 10) || (idx == 11);
    endfunction
endpackage

// File: rtl/serport_rxfifo.sv
// Receive byte queue. Circular buffer with a separate count.
// A byte arriving while full is dropped, even if a pop occurs in the
// same cycle. A pop on an empty queue does nothing.
module serport_rxfifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         nonempty_nxt
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, count_nxt;
    logic          do_push, do_pop;

    // Qualify requests against the current fill state.
    always_comb begin
        full         = (count == CW'(DEPTH));
        empty        = (count == '0);
        do_push      = push && !full;
        do_pop       = pop && !empty;
        count_nxt    = count + CW'(do_push) - CW'(do_pop);
        nonempty_nxt = (count_nxt != '0);
        head         = mem[rd_ptr];
    end

    // Store accepted bytes at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance pointers and count with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count_nxt;
        end
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH))); // R2
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1)); // R4
    AST_SIMUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && push && !empty && !full) |=> $stable(count)); // R4
endmodule

// File: rtl/serport_irq.sv
// Interrupt state: raw bits, acknowledge word and the pending-transmit flag.
// Assumes at most one of wr_dout, wr_ack, wr_raw per cycle. The receive bit
// is refreshed only when 'recompute' is high.
module serport_irq #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          recompute,
    input  logic          nonempty_nxt,
    input  logic          wr_dout,
    input  logic          wr_ack,
    input  logic          wr_raw,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] raw,
    output logic [DW-1:0] ack_val,
    output logic [DW-1:0] masked,
    output logic          irq
);
    import serport_pkg::*;

    logic          pending, pending_n;
    logic [DW-1:0] raw_n, ack_n, eff;

    // Next-state for raw bits, acknowledge word and pending flag.
    always_comb begin
        raw_n     = raw;
        ack_n     = ack_val;
        pending_n = pending;
        eff       = pending ? (wdata & ~DW'(1)) : wdata;
        if (wr_dout) begin
            raw_n     = raw | DW'(3);
            pending_n = 1'b1;
        end else if (wr_ack) begin
            ack_n     = eff;
            raw_n     = raw & ~eff;
            pending_n = 1'b0;
        end else if (wr_raw) begin
            raw_n = wdata;
        end
        if (recompute) raw_n[RAW_RX_BIT] = nonempty_nxt;
    end

    // Register the interrupt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw     <= '0;
            ack_val <= '0;
            pending <= 1'b0;
        end else begin
            raw     <= raw_n;
            ack_val <= ack_n;
            pending <= pending_n;
        end
    end

    // Masked view and interrupt line.
    always_comb begin
        masked = raw & mask;
        irq    = |masked;
    end

    AST_DOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dout |=> (raw[1:0] == 2'b11)); // R6
    AST_ACK_KEEP0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && pending) |=> (raw[0] == $past(raw[0]))); // R7
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !pending) |=> ((raw & $past(wdata) & ~DW'(8)) == '0)); // R7
    AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !recompute |=> (raw[RAW_RX_BIT] == $past(raw[RAW_RX_BIT]))); // R5
endmodule

// File: rtl/serport_regs.sv
// Serial port register front end: word-indexed register port, receive
// queue, transmit strobe and interrupt logic. All accesses are 32-bit.
// Read data is registered one cycle after rd_en.
module serport_regs #(
    parameter int FIFO_DEPTH = 16,
    parameter int BYTE_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [serport_pkg::IDX_W-1:0] reg_idx,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [serport_pkg::DW-1:0]  wr_data,
    output logic [serport_pkg::DW-1:0]  rd_data,
    input  logic                        rx_valid,
    input  logic [BYTE_W-1:0]           rx_byte,
    output logic                        tx_valid,
    output logic [BYTE_W-1:0]           tx_byte,
    output logic                        irq
);
    import serport_pkg::*;

    localparam int NSLOTS = 2 ** IDX_W;

    logic [DW-1:0]     word [NSLOTS];
    logic [DW-1:0]     raw, ack_val, masked, status;
    logic [BYTE_W-1:0] head;
    logic              empty, full, nonempty_nxt;
    logic              rx_accept, pop_rd;

    // Request decode for the queue.
    always_comb begin
        rx_accept = rx_valid && word[IDX_RXCTRL][RXEN_BIT];
        pop_rd    = rd_en && (reg_idx == IDX_POP);
    end

    // Plain storage slots; unbacked slots read zero.
    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        if (is_plain(i)) begin : g_store
            // Hold one software-written word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word[i] <= (i == IDX_RXCTRL) ? RXCTRL_RST : '0;
                else if (wr_en && (reg_idx == IDX_W'(i)))
                    word[i] <= wr_data;
            end
        end else begin : g_none
            assign word[i] = '0;
        end
    end

    serport_rxfifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_accept), .din(rx_byte), .pop(pop_rd),
        .head(head), .empty(empty), .full(full), .nonempty_nxt(nonempty_nxt)
    );

    serport_irq #(.DW(DW)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .recompute(wr_en || rx_accept), .nonempty_nxt(nonempty_nxt),
        .wr_dout(wr_en && (reg_idx == IDX_DOUT)),
        .wr_ack(wr_en && (reg_idx == IDX_ACK)),
        .wr_raw(wr_en && (reg_idx == IDX_RAW)),
        .wdata(wr_data), .mask(word[IDX_MASK]),
        .raw(raw), .ack_val(ack_val), .masked(masked), .irq(irq)
    );

    // Status/data word shared by popping and peeking reads.
    always_comb begin
        status               = '0;
        status[BYTE_W-1:0]   = head;
        status[ST_AVAIL_BIT] = !empty;
        status[ST_IDLE_BIT]  = 1'b1;
        status[ST_READY_BIT] = 1'b1;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en) begin
            case (reg_idx)
                IDX_POP, IDX_PEEK: rd_data <= status;
                IDX_ACK:           rd_data <= ack_val;
                IDX_RAW:           rd_data <= raw;
                IDX_MASKED:        rd_data <= masked;
                default:           rd_data <= word[reg_idx];
            endcase
        end
    end

    // Transmit strobe: one cycle per data-out write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= wr_en && (reg_idx == IDX_DOUT);
            if (wr_en && (reg_idx == IDX_DOUT)) tx_byte <= wr_data[BYTE_W-1:0];
        end
    end

    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_DOUT) |=> (tx_valid && tx_byte == $past(wr_data[BYTE_W-1:0]))); // R6
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !word[IDX_RXCTRL][RXEN_BIT] && !pop_rd) |=> $stable(empty)); // R9
    AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (reg_idx == IDX_POP || reg_idx == IDX_PEEK)) |=> (rd_data[ST_READY_BIT] && rd_data[ST_IDLE_BIT])); // R3
endmodule

// File: tb/tb_serport_regs.sv
module tb_serport_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rx_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  rx_byte = '0;
    logic        tx_valid, irq;
    logic [7:0]  tx_byte;
    int          checks = 0, errors = 0;
    bit          done = 0;
    logic [31:0] v;

    localparam logic [31:0] ST_BASE = 32'h0140_0000;
    localparam logic [31:0] ST_AV   = 32'h0001_0000;

    always #4 clk = ~clk;

    serport_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] idx, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; reg_idx = idx; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] idx, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; reg_idx = idx;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic push(logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pop_push(logic [7:0] b, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; reg_idx = 4'd8; rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rd_en = 1'b0; rx_valid = 1'b0; d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd2, v);  chk("R1 rxctrl reset", v, 32'h0001_0000);
        rd(4'd11, v); chk("R1 mask reset", v, 0);
        chk("R1 irq low", {31'b0, irq}, 0);
        chk("R1 tx_valid low", {31'b0, tx_valid}, 0);
        rd(4'd9, v);  chk("R3 empty status", v & 32'hFFFF_FF00, ST_BASE);
        // R9 reception disabled
        push(8'hAA);
        rd(4'd9, v);  chk("R9 byte ignored while disabled", v & 32'hFFFF_FF00, ST_BASE);
        wr(4'd2, 32'h8);
        for (int i = 0; i < 17; i++) push(pat(i));
        rd(4'd9, v);  chk("R3 peek head", v, ST_BASE | ST_AV | 32'(pat(0)));
        rd(4'd9, v);  chk("R4 peek keeps head", v, ST_BASE | ST_AV | 32'(pat(0)));
        rd(4'd13, v); chk("R5 raw rx bit set", v, 32'h8);
        // R2 order and overflow drop
        for (int i = 0; i < 16; i++) begin
            rd(4'd8, v); chk("R2 pop order", v, ST_BASE | ST_AV | 32'(pat(i)));
        end
        rd(4'd9, v);  chk("R2 17th byte dropped", v & 32'hFFFF_FF00, ST_BASE);
        rd(4'd8, v);  chk("R4 pop on empty", v & 32'hFFFF_FF00, ST_BASE);
        rd(4'd13, v); chk("R5 raw bit sticky after pop", v, 32'h8);
        wr(4'd11, 32'h8);
        rd(4'd13, v); chk("R5 raw bit refreshed by write", v, 0);
        chk("R8 irq low", {31'b0, irq}, 0);
        push(8'h5A);
        chk("R8 irq high", {31'b0, irq}, 1);
        rd(4'd14, v); chk("R8 masked word", v, 32'h8);
        pop_push(8'h77, v);
        chk("R4 simultaneous pop data", v, ST_BASE | ST_AV | 32'h5A);
        rd(4'd9, v);  chk("R4 simultaneous keeps count", v, ST_BASE | ST_AV | 32'h77);
        rd(4'd8, v);
        rd(4'd9, v);  chk("R4 empty after pop", v & 32'hFFFF_FF00, ST_BASE);
        // R6 transmit
        wr(4'd7, 32'h1234_56C3);
        chk("R6 tx_valid pulse", {31'b0, tx_valid}, 1);
        chk("R6 tx_byte", {24'b0, tx_byte}, 32'hC3);
        @(negedge clk);
        chk("R6 tx_valid one cycle", {31'b0, tx_valid}, 0);
        rd(4'd7, v);  chk("R6 dout stored", v, 32'h1234_56C3);
        rd(4'd13, v); chk("R6 raw bits 0 and 1", v, 32'h3);
        // R7 acknowledge
        wr(4'd12, 32'h3);
        rd(4'd13, v); chk("R7 first ack keeps bit0", v, 32'h1);
        rd(4'd12, v); chk("R7 ack stored effective", v, 32'h2);
        wr(4'd12, 32'h1);
        rd(4'd13, v); chk("R7 second ack clears bit0", v, 0);
        rd(4'd12, v); chk("R7 ack stored", v, 32'h1);
        // R8 mask sweep
        wr(4'd7, 32'h0);
        for (int m = 0; m < 16; m++) begin
            wr(4'd11, 32'(m));
            chk("R8 irq level", {31'b0, irq}, 32'(((3 & m) != 0) ? 1 : 0));
            rd(4'd14, v); chk("R8 masked sweep", v, 32'(3 & m));
        end
        // R10 ignored and unbacked slots
        wr(4'd14, 32'hFFFF);
        rd(4'd14, v); chk("R10 masked write ignored", v, 32'h3);
        wr(4'd15, 32'hDEAD_BEEF);
        rd(4'd15, v); chk("R10 slot 15 zero", v, 0);
        // R11 raw write
        wr(4'd13, 32'hFF);
        rd(4'd13, v); chk("R11 raw write bit3 forced low", v, 32'hF7);
        push(8'h11);
        wr(4'd13, 32'h0);
        rd(4'd13, v); chk("R11 raw write bit3 forced high", v, 32'h8);
        // R10 plain storage sweep
        for (int k = 0; k < 16; k++) begin
            if (k <= 7 || k == 10 || k == 11) begin
                logic [31:0] d;
                d = (32'(k) * 32'h0101_0101) ^ 32'hA5A5_0000;
                wr(4'(k), d);
                if (k == 7) @(negedge clk);
                rd(4'(k), v); chk("R10 plain storage", v, d);
            end
        end
        finish_run();
    end
endmodule